// File: doc/BRIEF.md
# Clock System with Fail-Safe Fallback

This block derives five system clock streams from seven oscillator streams: an auxiliary clock, a main clock, a high-speed subsystem clock, a low-speed subsystem clock and a low-speed backup clock. Each oscillator arrives as a clock-enable pulse stream sampled on one fast reference clock `clk`. Each output picks one source through a glitch-free selector and then divides the picked stream by a power of two. Every output is itself a pulse stream on `clk`.

A monitor watches the two external crystals and the resistor status of the digitally controlled oscillator. A crystal is faulty when software has it disabled. It is also faulty when a programmable number of very-low-power oscillator pulses pass with no pulse from the crystal. Any output that selects a faulty crystal is steered to a fail-safe source without software taking part, and it returns to the crystal once the crystal recovers. Each fault leaves a sticky flag that software clears with a write of one.

Software controls the block through a write-only register port. Out of reset the two slow outputs point at the low-speed crystal. That crystal starts disabled, so those outputs begin on the fallback source.

Top module: `cs_clock_sys`

## Requirements
- R1: Out of reset the main clock and both subsystem clocks run from the digitally controlled oscillator (code 3) at ratio 1. The auxiliary and backup clocks select the disabled low-speed crystal and therefore run from the reference oscillator (code 2). `fault_flags` reads 0 while reset is held and reads 3'b011 from the first edge after release. `dco_int_res` reads 1.
- R2: A write to address 0 (auxiliary), 1 (main), 2 (high-speed subsystem), 3 (low-speed subsystem) or 4 (backup) loads data bits [2:0] as the source code and bits [6:4] as the divide exponent. The source codes are: 0 low-speed crystal, 1 very-low-power, 2 reference, 3 digitally controlled, 4 module, 5 high-speed crystal, 6 system oscillator.
- R3: With divide exponent d (0 to 7), an output emits one pulse for every 2^d pulses of its source, so its pulse spacing is the source spacing times 2^d.
- R4: The main clock and the subsystem clocks accept source codes 0 to 5. The auxiliary clock accepts only 0 to 2, and the backup clock accepts only 0 or 2. A write that carries a code the output does not accept is ignored entirely, and the output keeps its source and ratio.
- R5: Bit 0 of address 5 enables the low-speed crystal and bit 1 enables the high-speed crystal; both reset to 0. A crystal is faulty while it is disabled, or once the count in address 7 (reset value `WIN_DEF`) of very-low-power pulses has passed without a crystal pulse. Its flag (bit 0 low-speed, bit 1 high-speed) is set on the following edge.
- R6: While the low-speed crystal is faulty, outputs that select it run from the reference oscillator. While the high-speed crystal is faulty, outputs that select it run from the system oscillator. Each output returns to its crystal by itself when the fault ends.
- R7: Bit 2 of address 5 selects the external resistor. While it is selected and `rext_ok` is low, `dco_int_res` is 1 and flag bit 2 is set. `dco_int_res` is also 1 whenever the external resistor is not selected.
- R8: A fault flag stays set until a write to address 6 carries a 1 in the flag's bit position. The clear has no effect while the fault is still present.
- R9: A source change releases the old source only in a cycle when its pulse is low. It then spends one cycle with no output pulse before it enables the new source. Its divider restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock that samples all streams |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| lfxt_tick | input | 1 | Low-speed crystal pulse stream |
| vlo_tick | input | 1 | Very-low-power oscillator pulse stream |
| refo_tick | input | 1 | Reference oscillator pulse stream |
| dco_tick | input | 1 | Digitally controlled oscillator pulse stream |
| mod_tick | input | 1 | Module oscillator pulse stream |
| hfxt_tick | input | 1 | High-speed crystal pulse stream |
| sys_tick | input | 1 | System oscillator pulse stream |
| rext_ok | input | 1 | External resistor of the controlled oscillator is intact |
| aux_tick | output | 1 | Auxiliary clock stream |
| main_tick | output | 1 | Main clock stream |
| hsub_tick | output | 1 | High-speed subsystem clock stream |
| lsub_tick | output | 1 | Low-speed subsystem clock stream |
| bk_tick | output | 1 | Backup clock stream |
| fault_flags | output | 3 | Sticky flags: bit 0 low-speed crystal, bit 1 high-speed crystal, bit 2 resistor |
| dco_int_res | output | 1 | The controlled oscillator uses its internal resistor |

## Verification
The bench builds the block with `WIN_DEF` = 4 and keeps `DIV_W` at 3. With a very-low-power spacing of 40 cycles, a stalled crystal is declared faulty about 160 cycles after its last pulse. That makes the check just before the window ends and the check just after it both cheap. Keeping `DIV_W` at 3 leaves the full ratio range of 1 to 128 reachable, including the 384-cycle spacing at the top end. Every source has its own spacing, so a measured output spacing shows both the source that was picked and the divide exponent.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int SEL_W = 3;
  localparam int NOUT  = 5;
  localparam int NFLT  = 3;

  localparam logic [SEL_W-1:0] S_LFXT = 3'd0;
  localparam logic [SEL_W-1:0] S_VLO  = 3'd1;
  localparam logic [SEL_W-1:0] S_REFO = 3'd2;
  localparam logic [SEL_W-1:0] S_DCO  = 3'd3;
  localparam logic [SEL_W-1:0] S_MOD  = 3'd4;
  localparam logic [SEL_W-1:0] S_HFXT = 3'd5;
  localparam logic [SEL_W-1:0] S_SYS  = 3'd6;

  localparam int O_AUX = 0;
  localparam int O_BK  = 4;

  // Which source codes a given output may be steered to.
  function automatic logic sel_legal(int unsigned o, logic [SEL_W-1:0] s);
    if (o == O_AUX) return s <= S_REFO;
    if (o == O_BK)  return (s == S_LFXT) || (s == S_REFO);
    return s <= S_HFXT;
  endfunction

  function automatic logic [SEL_W-1:0] sel_default(int unsigned o);
    return ((o == O_AUX) || (o == O_BK)) ? S_LFXT : S_DCO;
  endfunction

  // Fail-safe steering of a software selection.
  function automatic logic [SEL_W-1:0] sel_fallback(logic [SEL_W-1:0] s,
                                                    logic lf_bad, logic hf_bad);
    if (s == S_LFXT && lf_bad) return S_REFO;
    if (s == S_HFXT && hf_bad) return S_SYS;
    return s;
  endfunction
endpackage

// File: rtl/cs_xtal_mon.sv
module cs_xtal_mon #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             xt_tick,
  input  logic             ref_tick,
  input  logic [WIN_W-1:0] win,
  output logic             fault
);
  localparam logic [WIN_W-1:0] CNT_MAX = '1;

  logic [WIN_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                           gap_q <= '0;
    else if (xt_tick)                     gap_q <= '0;
    else if (ref_tick && gap_q != CNT_MAX) gap_q <= gap_q + 1'b1;
  end

  assign fault = !en || (gap_q >= win);
endmodule

// File: rtl/cs_src_switch.sv
module cs_src_switch #(
  parameter int               SEL_W   = 3,
  parameter logic [SEL_W-1:0] RST_SEL = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2**SEL_W-1:0]   src,
  input  logic [SEL_W-1:0]      want,
  output logic                  tick,
  output logic [SEL_W-1:0]      cur,
  output logic                  parked
);
  logic release_ok;
  assign release_ok = (want != cur) && !src[cur];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= RST_SEL;
      parked <= 1'b0;
    end else if (parked) begin
      cur    <= want;
      parked <= 1'b0;
    end else if (release_ok) begin
      parked <= 1'b1;
    end
  end

  assign tick = !parked && src[cur];
endmodule

// File: rtl/cs_pow2_div.sv
module cs_pow2_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_in,
  input  logic [DIV_W-1:0] dexp,
  output logic             tick_out
);
  localparam int CW = (1 << DIV_W) - 1;

  // Terminal count 2^d - 1 built as a thermometer code.
  function automatic logic [CW-1:0] last_count(logic [DIV_W-1:0] d);
    logic [CW-1:0] r;
    for (int i = 0; i < CW; i++) r[i] = (i < int'(d));
    return r;
  endfunction

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end   = cnt_q >= last_count(dexp);
  assign tick_out = tick_in && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (tick_in)  cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cs_clock_sys.sv
module cs_clock_sys
  import cs_pkg::*;
#(
  parameter int DIV_W   = 3,
  parameter int WIN_W   = 8,
  parameter int WIN_DEF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       lfxt_tick,
  input  logic       vlo_tick,
  input  logic       refo_tick,
  input  logic       dco_tick,
  input  logic       mod_tick,
  input  logic       hfxt_tick,
  input  logic       sys_tick,
  input  logic       rext_ok,
  output logic       aux_tick,
  output logic       main_tick,
  output logic       hsub_tick,
  output logic       lsub_tick,
  output logic       bk_tick,
  output logic [2:0] fault_flags,
  output logic       dco_int_res
);
  localparam logic [2:0] A_CTL = 3'd5;
  localparam logic [2:0] A_CLR = 3'd6;
  localparam logic [2:0] A_WIN = 3'd7;
  localparam int         NSRC  = 2 ** SEL_W;

  logic [SEL_W-1:0] sel_q  [NOUT];
  logic [DIV_W-1:0] dexp_q [NOUT];
  logic [SEL_W-1:0] want_a [NOUT];
  logic [2:0]       ctl_q;
  logic [WIN_W-1:0] win_q;
  logic [NFLT-1:0]  flags_q;

  // Named internal events, observed by the bound checker.
  logic [NSRC-1:0]       src_v;
  logic [NOUT*SEL_W-1:0] cur_v;
  logic [NOUT-1:0]       park_v;
  logic [NOUT-1:0]       tick_v;
  logic [NFLT-1:0]       fault_now;
  logic [NFLT-1:0]       clr_v;

  assign src_v = {1'b0, sys_tick, hfxt_tick, mod_tick, dco_tick,
                  refo_tick, vlo_tick, lfxt_tick};

  // Register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int o = 0; o < NOUT; o++) begin
        sel_q[o]  <= sel_default(o);
        dexp_q[o] <= '0;
      end
      ctl_q <= '0;
      win_q <= WIN_W'(WIN_DEF);
    end else if (wr_en) begin
      for (int o = 0; o < NOUT; o++) begin
        if (int'(wr_addr) == o && sel_legal(o, wr_data[SEL_W-1:0])) begin
          sel_q[o]  <= wr_data[SEL_W-1:0];
          dexp_q[o] <= wr_data[4 +: DIV_W];
        end
      end
      if (wr_addr == A_CTL) ctl_q <= wr_data[2:0];
      if (wr_addr == A_WIN) win_q <= wr_data[WIN_W-1:0];
    end
  end

  // Fault detection
  cs_xtal_mon #(.WIN_W(WIN_W)) u_lf_mon (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[0]), .xt_tick(lfxt_tick),
    .ref_tick(vlo_tick), .win(win_q), .fault(fault_now[0])
  );
  cs_xtal_mon #(.WIN_W(WIN_W)) u_hf_mon (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[1]), .xt_tick(hfxt_tick),
    .ref_tick(vlo_tick), .win(win_q), .fault(fault_now[1])
  );
  assign fault_now[2] = ctl_q[2] && !rext_ok;
  assign dco_int_res  = !ctl_q[2] || !rext_ok;

  assign clr_v = (wr_en && wr_addr == A_CLR) ? wr_data[NFLT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= fault_now | (flags_q & ~clr_v);
  end
  assign fault_flags = flags_q;

  // Source steering
  always_comb begin
    for (int o = 0; o < NOUT; o++)
      want_a[o] = sel_fallback(sel_q[o], fault_now[0], fault_now[1]);
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic             sw_tick;
    logic [SEL_W-1:0] sw_cur;
    logic             sw_park;

    cs_src_switch #(.SEL_W(SEL_W), .RST_SEL(sel_default(o))) u_sw (
      .clk(clk), .rst_n(rst_n), .src(src_v), .want(want_a[o]),
      .tick(sw_tick), .cur(sw_cur), .parked(sw_park)
    );
    cs_pow2_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(sw_park), .tick_in(sw_tick),
      .dexp(dexp_q[o]), .tick_out(tick_v[o])
    );
    assign cur_v[o*SEL_W +: SEL_W] = sw_cur;
    assign park_v[o]               = sw_park;
  end

  assign aux_tick  = tick_v[0];
  assign main_tick = tick_v[1];
  assign hsub_tick = tick_v[2];
  assign lsub_tick = tick_v[3];
  assign bk_tick   = tick_v[4];
endmodule

// File: rtl/cs_clock_sys_chk.sv
module cs_clock_sys_chk
  import cs_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [2**SEL_W-1:0]   src_v,
  input logic [NOUT*SEL_W-1:0] cur_v,
  input logic [NOUT-1:0]       park_v,
  input logic [NOUT-1:0]       tick_v,
  input logic [NFLT-1:0]       fault_now,
  input logic [NFLT-1:0]       flags,
  input logic [NFLT-1:0]       clr_v,
  input logic                  dco_int
);
  // R4: the slow outputs only ever run from slow sources
  a_r4_aux_slow: assert property (@(posedge clk) disable iff (!rst_n)
    cur_v[O_AUX*SEL_W +: SEL_W] <= S_REFO);
  a_r4_bk_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_v[O_BK*SEL_W +: SEL_W] == S_LFXT) || (cur_v[O_BK*SEL_W +: SEL_W] == S_REFO));

  // R7: a resistor fault always goes with the internal resistor
  a_r7_int_res: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now[2] |-> dco_int);

  for (genvar f = 0; f < NFLT; f++) begin : g_flag
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      fault_now[f] |=> flags[f]);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[f] && !clr_v[f]) |=> flags[f]);
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_sw
    a_r9_release_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(park_v[k]) |-> !$past(src_v[cur_v[k*SEL_W +: SEL_W]]));
    a_r9_change_via_park: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_v[k*SEL_W +: SEL_W]) |-> $past(park_v[k]));
    a_r9_quiet_parked: assert property (@(posedge clk) disable iff (!rst_n)
      park_v[k] |-> !tick_v[k]);
  end
endmodule

bind cs_clock_sys cs_clock_sys_chk chk_i (
  .clk(clk), .rst_n(rst_n), .src_v(src_v), .cur_v(cur_v), .park_v(park_v),
  .tick_v(tick_v), .fault_now(fault_now), .flags(fault_flags), .clr_v(clr_v),
  .dco_int(dco_int_res)
);

// File: tb/cs_clock_sys_tb_top.sv
module cs_clock_sys_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic lfxt_tick = 0, vlo_tick = 0, refo_tick = 0, dco_tick = 0;
  logic mod_tick = 0, hfxt_tick = 0, sys_tick = 0, rext_ok = 1;
  logic aux_tick, main_tick, hsub_tick, lsub_tick, bk_tick, dco_int_res;
  logic [2:0] fault_flags;
  logic [4:0] outs;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0, lf_run = 0, hf_run = 1;

  assign outs = {bk_tick, lsub_tick, hsub_tick, main_tick, aux_tick};

  cs_clock_sys #(.WIN_DEF(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lfxt_tick(lfxt_tick), .vlo_tick(vlo_tick), .refo_tick(refo_tick),
    .dco_tick(dco_tick), .mod_tick(mod_tick), .hfxt_tick(hfxt_tick),
    .sys_tick(sys_tick), .rext_ok(rext_ok), .aux_tick(aux_tick),
    .main_tick(main_tick), .hsub_tick(hsub_tick), .lsub_tick(lsub_tick),
    .bk_tick(bk_tick), .fault_flags(fault_flags), .dco_int_res(dco_int_res)
  );

  // Pulse spacing of each source code, in clk cycles
  function automatic int src_gap(int s);
    case (s)
      0: return 5;  1: return 40; 2: return 7; 3: return 3;
      4: return 2;  5: return 4;  default: return 6;
    endcase
  endfunction

  function automatic int exp_gap(int s, int d);
    return src_gap(s) * (1 << d);
  endfunction

  function automatic logic [7:0] cfg(int s, int d);
    return 8'((d << 4) | s);
  endfunction

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    lfxt_tick = lf_run && (cyc % src_gap(0) == 0);
    vlo_tick  = (cyc % src_gap(1) == 0);
    refo_tick = (cyc % src_gap(2) == 0);
    dco_tick  = (cyc % src_gap(3) == 0);
    mod_tick  = (cyc % src_gap(4) == 0);
    hfxt_tick = hf_run && (cyc % src_gap(5) == 0);
    sys_tick  = (cyc % src_gap(6) == 0);
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic next_pulse(int idx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!outs[idx] && n < 20000);
  endtask

  task automatic measure(int idx, output int gap);
    int d;
    idle(20);
    next_pulse(idx, d);
    next_pulse(idx, d);
    next_pulse(idx, d);
    gap = d;
  endtask

  task automatic gap_mon(int idx, int n, output int mn);
    int last;
    last = -1; mn = 1000;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outs[idx]) begin
        if (last >= 0 && i - last < mn) mn = i - last;
        last = i;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int g, mn;
    void'($urandom(32'd20240611));
    idle(3);
    check("R1 flags in reset", int'(fault_flags), 0);
    rst_n = 1'b1;
    idle(3);
    check("R1 flags after reset", int'(fault_flags), 3);
    check("R1/R7 internal resistor", int'(dco_int_res), 1);
    measure(0, g); check("R1 aux on reference", g, exp_gap(2, 0));
    measure(1, g); check("R1 main on DCO", g, exp_gap(3, 0));
    measure(2, g); check("R1 hsub on DCO", g, exp_gap(3, 0));
    measure(3, g); check("R1 lsub on DCO", g, exp_gap(3, 0));
    measure(4, g); check("R1 backup on reference", g, exp_gap(2, 0));

    // R3 divider ratios, including the top one
    wr(3'd1, cfg(3, 3)); measure(1, g); check("R3 main ratio 8", g, exp_gap(3, 3));
    wr(3'd1, cfg(3, 7)); measure(1, g); check("R3 main ratio 128", g, exp_gap(3, 7));
    wr(3'd1, cfg(3, 0));

    // R4 illegal selects ignored, legal one taken (R2)
    wr(3'd0, cfg(3, 2)); measure(0, g); check("R4 aux rejects code 3", g, exp_gap(2, 0));
    wr(3'd4, cfg(1, 1)); measure(4, g); check("R4 backup rejects code 1", g, exp_gap(2, 0));
    wr(3'd0, cfg(1, 0)); measure(0, g); check("R2 aux takes VLO", g, exp_gap(1, 0));
    wr(3'd0, cfg(0, 0));

    // R5/R6/R8 low-speed crystal
    lf_run = 1; wr(3'd5, 8'h01); idle(50);
    wr(3'd6, 8'h01); idle(2);
    check("R8 clear when healthy", int'(fault_flags[0]), 0);
    measure(0, g); check("R6 aux on crystal", g, exp_gap(0, 0));
    measure(4, g); check("R6 backup on crystal", g, exp_gap(0, 0));
    lf_run = 0; idle(40);
    check("R5 no fault inside window", int'(fault_flags[0]), 0);
    idle(260);
    check("R5 fault after window", int'(fault_flags[0]), 1);
    measure(0, g); check("R6 aux falls back", g, exp_gap(2, 0));
    wr(3'd6, 8'h01); idle(2);
    check("R8 clear ignored while faulty", int'(fault_flags[0]), 1);
    lf_run = 1; idle(30);
    measure(0, g); check("R6 aux returns to crystal", g, exp_gap(0, 0));
    check("R8 flag held after recovery", int'(fault_flags[0]), 1);
    wr(3'd6, 8'h01); idle(2);
    check("R8 flag cleared", int'(fault_flags[0]), 0);

    // R6/R5 high-speed crystal
    wr(3'd1, cfg(5, 0)); measure(1, g); check("R6 main to system osc", g, exp_gap(6, 0));
    wr(3'd5, 8'h03); measure(1, g); check("R5 main on enabled crystal", g, exp_gap(5, 0));
    wr(3'd6, 8'h02); idle(2);
    check("R8 high-speed flag cleared", int'(fault_flags[1]), 0);

    // R7 resistor
    rext_ok = 0; wr(3'd5, 8'h07); idle(2);
    check("R7 internal resistor on fault", int'(dco_int_res), 1);
    check("R7 resistor flag", int'(fault_flags[2]), 1);
    rext_ok = 1; idle(2);
    check("R7 external resistor used", int'(dco_int_res), 0);
    check("R8 resistor flag held", int'(fault_flags[2]), 1);
    wr(3'd6, 8'h04); idle(2);
    check("R8 resistor flag cleared", int'(fault_flags), 0);

    // R9 glitch-free change of source
    wr(3'd1, cfg(4, 0)); idle(20);
    fork
      wr(3'd1, cfg(3, 0));
      gap_mon(1, 80, mn);
    join
    check("R9 no short pulse gap", int'(mn >= 2), 1);
    measure(1, g); check("R9 new source after switch", g, exp_gap(3, 0));

    // Random selections on the low-speed subsystem clock
    for (int i = 0; i < 10; i++) begin
      int s, d;
      s = int'($urandom % 6);
      d = int'($urandom % 4);
      wr(3'd3, cfg(s, d));
      measure(3, g);
      check("R2/R3 random lsub", g, exp_gap(s, d));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule